// File: doc/BRIEF.md
# Prescaled SCL Clock Generator

This block times the clock line of a two-wire serial bus master. A prescaler first divides the functional clock by N+1 to form a slower module tick. Each tick then advances a counter that sets how long SCL is pulled low, and afterwards how long it is left high. The low and the high durations are programmed separately. The block adds a fixed number of ticks to each programmed value and subtracts a correction that grows with the prescale value but stops at a cap. This lets a period value of (module kHz / (2 x target kHz)) - 7 give standard or fast bus rates.

The generator runs only while both `enable` and `active` are high. At all other times SCL is released. A transaction sequencer uses the `tick_fall` pulse to know when a low phase starts and the `tick_rise` pulse to know when a counted high phase starts. When the line is released, the high count begins only after the line is sensed high, so a slave that holds SCL low stretches the clock. The prescale and period inputs are sampled only when a phase begins, so a change made mid-phase applies from the next phase.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, or while `enable` or `active` is low, `scl_drive_low` is 0 and neither tick output is ever asserted.
- R2: The prescaler advances the phase counter once every N+1 clock cycles, where N is `psc_val`, so every phase duration is a multiple of N+1 cycles.
- R3: A low phase keeps `scl_drive_low` at 1 for exactly (L + OFFSET - C) x (N+1) cycles, with L = `low_val`, OFFSET = 7 and C = min(N, CORR_CAP) where CORR_CAP = 2.
- R4: The counted high phase lasts exactly (H + OFFSET - C) x (N+1) cycles, with H = `high_val`. It is measured from the cycle in which `tick_rise` is 1 up to, but not including, the next `tick_fall` cycle.
- R5: After SCL is released, the high count starts the cycle after `scl_sense` is first seen high. With the line held low for S >= 1 cycles after release, `tick_rise` follows release by S cycles, or by 1 cycle if nothing holds the line.
- R6: The correction C never exceeds CORR_CAP: at N = 3 both phases last (value + 5) x 4 cycles.
- R7: The prescale and period inputs are sampled only when a phase begins. A change made during a low phase leaves that low phase unchanged and applies to the following high phase and to later phases.
- R8: `tick_fall` is a one-cycle pulse in the first cycle of each low phase, in which `scl_drive_low` is already 1. `tick_rise` is a one-cycle pulse in the first counted high cycle. The two are never 1 together.
- R9: Dropping `active` or `enable` in the middle of a phase releases SCL by the next cycle, and no tick follows while it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable |
| active | input | 1 | Transfer in progress |
| psc_val | input | PSC_W | Prescale value N (divide by N+1) |
| low_val | input | PER_W | Low-phase period value |
| high_val | input | PER_W | High-phase period value |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| tick_fall | output | 1 | Pulse at the start of a low phase |
| tick_rise | output | 1 | Pulse at the start of a counted high phase |

## Verification
The bench builds the block with a 3-bit prescale field, 6-bit period fields, an offset of 7 and a correction cap of 2. The narrow prescale field still reaches N = 3, where the cap applies. The short periods keep each phase to a few tens of cycles, so it can be measured exactly. A bench model of the bus wires the sense input to the drive output and can hold the line low for a set number of cycles. With this model one bench can measure stretched high phases, changes made mid-phase and stopping mid-phase.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;
endpackage

// File: rtl/scl_len_calc.sv
module scl_len_calc #(
   parameter int PSC_W    = 8,
   parameter int PER_W    = 8,
   parameter int OFFSET   = 7,
   parameter int CORR_CAP = 2,
   parameter int LEN_W    = 9
) (
   input  logic [PSC_W-1:0] psc,
   input  logic [PER_W-1:0] per,
   output logic [LEN_W-1:0] len
);
   generate
      if (CORR_CAP == 0) begin : g_nocorr
         assign len = LEN_W'(per) + LEN_W'(OFFSET);
      end else begin : g_corr
         localparam int CW = $clog2(CORR_CAP + 1);
         logic [CW-1:0] corr;
         always_comb begin
            if (int'(psc) >= CORR_CAP) corr = CW'(CORR_CAP);
            else                       corr = CW'(psc);
         end
         assign len = LEN_W'(per) + LEN_W'(OFFSET) - LEN_W'(corr);
      end
   endgenerate
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (tick)   cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;
   end

   // R2: the divider count never passes the programmed divide value
   a_r2_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= div));
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [LEN_W-1:0] limit,
   output logic             done
);
   logic [LEN_W-1:0] cnt;

   assign done = step && (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (done)   cnt <= '0;
      else if (step)   cnt <= cnt + 1'b1;
   end

   // R3: phase counter stays inside the latched phase length
   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < limit);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
   import scl_clkgen_pkg::*;
#(
   parameter int PSC_W    = 8,
   parameter int PER_W    = 8,
   parameter int OFFSET   = 7,
   parameter int CORR_CAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             active,
   input  logic [PSC_W-1:0] psc_val,
   input  logic [PER_W-1:0] low_val,
   input  logic [PER_W-1:0] high_val,
   input  logic             scl_sense,
   output logic             scl_drive_low,
   output logic             tick_fall,
   output logic             tick_rise
);
   localparam int LEN_W = $clog2((2 ** PER_W) + OFFSET);

   generate
      if (PSC_W < 1 || PER_W < 1) begin : g_bad_width
         $error("scl_clkgen: PSC_W and PER_W must be at least 1");
      end
      if (OFFSET <= CORR_CAP) begin : g_bad_offset
         $error("scl_clkgen: OFFSET must exceed CORR_CAP");
      end
   endgenerate

   scl_phase_e       state, state_d;
   logic [PSC_W-1:0] psc_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] low_len, high_len;
   logic             fall_q, rise_q;
   logic             run, go_low, go_high, load, cnt_run, pre_tick, done;

   assign run     = enable && active;
   assign load    = go_low || go_high;
   assign cnt_run = run && (state == PH_LOW || state == PH_HIGH);

   scl_len_calc #(.PSC_W(PSC_W), .PER_W(PER_W), .OFFSET(OFFSET),
                  .CORR_CAP(CORR_CAP), .LEN_W(LEN_W)) u_low_len (
      .psc(psc_val), .per(low_val), .len(low_len));

   scl_len_calc #(.PSC_W(PSC_W), .PER_W(PER_W), .OFFSET(OFFSET),
                  .CORR_CAP(CORR_CAP), .LEN_W(LEN_W)) u_high_len (
      .psc(psc_val), .per(high_val), .len(high_len));

   scl_prescaler #(.PSC_W(PSC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .clear(load), .run(cnt_run),
      .div(psc_q), .tick(pre_tick));

   scl_phase_timer #(.LEN_W(LEN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(load), .step(pre_tick),
      .limit(len_q), .done(done));

   always_comb begin
      state_d = state;
      go_low  = 1'b0;
      go_high = 1'b0;
      if (!run) begin
         state_d = PH_IDLE;
      end else begin
         case (state)
            PH_IDLE: go_low = 1'b1;
            PH_LOW:  if (done) state_d = PH_WAIT;
            PH_WAIT: if (scl_sense) go_high = 1'b1;
            PH_HIGH: if (done) go_low = 1'b1;
            default: state_d = PH_IDLE;
         endcase
         if (go_low)  state_d = PH_LOW;
         if (go_high) state_d = PH_HIGH;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PH_IDLE;
         psc_q  <= '0;
         len_q  <= LEN_W'(1);
         fall_q <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         state  <= state_d;
         fall_q <= go_low;
         rise_q <= go_high;
         if (load) begin
            psc_q <= psc_val;
            len_q <= go_low ? low_len : high_len;
         end
      end
   end

   assign scl_drive_low = (state == PH_LOW);
   assign tick_fall     = fall_q;
   assign tick_rise     = rise_q;

   // R9: losing enable or active releases the line by the next cycle
   a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!scl_drive_low && !tick_fall && !tick_rise));

   // R8: fall tick marks the first driven-low cycle
   a_r8_fall_first: assert property (@(posedge clk) disable iff (!rst_n)
      tick_fall |-> (scl_drive_low && !$past(scl_drive_low)));

   // R5: a counted high phase starts only after the line was seen high
   a_r5_rise_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
      tick_rise |-> ($past(scl_sense) && !scl_drive_low));

   // R8: ticks never coincide
   a_r8_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tick_fall, tick_rise}));

   // R7: latched settings hold for the whole of a phase
   a_r7_hold_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PH_LOW || state == PH_HIGH) && $past(state) == state && !tick_fall && !tick_rise)
      |-> ($stable(len_q) && $stable(psc_q)));
endmodule

// File: tb/tb_scl_clkgen.sv
module tb_scl_clkgen;
   localparam int CLK_PERIOD = 10;
   localparam int PSC_W = 3;
   localparam int PER_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             active = 1'b0;
   logic [PSC_W-1:0] psc_val = '0;
   logic [PER_W-1:0] low_val = '0;
   logic [PER_W-1:0] high_val = '0;
   logic             scl_sense;
   logic             scl_drive_low, tick_fall, tick_rise;

   int tests = 0;
   int fails = 0;
   int hcnt = 0;
   int stretch_s = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign scl_sense = !scl_drive_low && (hcnt == 0);

   scl_clkgen #(.PSC_W(PSC_W), .PER_W(PER_W), .OFFSET(7), .CORR_CAP(2)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .active(active),
      .psc_val(psc_val), .low_val(low_val), .high_val(high_val),
      .scl_sense(scl_sense), .scl_drive_low(scl_drive_low),
      .tick_fall(tick_fall), .tick_rise(tick_rise));

   // slave model: holds SCL low for stretch_s cycles after each release
   initial begin
      forever begin
         @(negedge clk);
         if (scl_drive_low) hcnt = stretch_s;
         else if (hcnt > 0) hcnt = hcnt - 1;
      end
   end

   function automatic int exp_len(int v, int n);
      int c;
      c = (n > 2) ? 2 : n;
      return (v + 7 - c) * (n + 1);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start(int n, int l, int h);
      active = 1'b0;
      repeat (2) @(negedge clk);
      psc_val  = PSC_W'(n);
      low_val  = PER_W'(l);
      high_val = PER_W'(h);
      active   = 1'b1;
   endtask

   task automatic measure(output int lo, output int wt, output int hi,
                          output int nf, output int nr);
      while (!tick_fall) @(negedge clk);
      lo = 0; wt = 0; hi = 0; nf = 0; nr = 0;
      while (scl_drive_low) begin
         lo++; if (tick_fall) nf++;
         @(negedge clk);
      end
      while (!tick_rise) begin wt++; @(negedge clk); end
      while (!tick_fall) begin
         hi++; if (tick_rise) nr++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_idle();
      int seen;
      check(scl_drive_low == 0 && !tick_fall && !tick_rise, "R1 reset state",
            int'(scl_drive_low), 0);
      enable = 1'b0; active = 1'b1; seen = 0;
      repeat (40) begin
         @(negedge clk);
         if (scl_drive_low || tick_fall || tick_rise) seen++;
      end
      check(seen == 0, "R1 disabled module", seen, 0);
      enable = 1'b1; active = 1'b0; seen = 0;
      repeat (40) begin
         @(negedge clk);
         if (scl_drive_low || tick_fall || tick_rise) seen++;
      end
      check(seen == 0, "R1 no transfer", seen, 0);
   endtask

   task automatic t_basic();
      int lo, wt, hi, nf, nr;
      start(0, 10, 20);
      while (!tick_fall) @(negedge clk);
      check(scl_drive_low == 1, "R8 fall tick with drive", int'(scl_drive_low), 1);
      measure(lo, wt, hi, nf, nr);
      check(lo == exp_len(10, 0), "R3 low length N=0", lo, exp_len(10, 0));
      check(wt == 1, "R5 unstretched wait", wt, 1);
      check(hi == exp_len(20, 0), "R4 high length N=0", hi, exp_len(20, 0));
      check(nf == 1, "R8 fall pulse width", nf, 1);
      check(nr == 1, "R8 rise pulse width", nr, 1);
   endtask

   task automatic t_prescale();
      int lo, wt, hi, nf, nr;
      start(1, 5, 3);
      measure(lo, wt, hi, nf, nr);
      check(lo == exp_len(5, 1), "R2 low with divide by 2", lo, exp_len(5, 1));
      check(hi == exp_len(3, 1), "R2 high with divide by 2", hi, exp_len(3, 1));
   endtask

   task automatic t_cap();
      int lo, wt, hi, nf, nr;
      start(3, 4, 4);
      measure(lo, wt, hi, nf, nr);
      check(lo == 36, "R6 capped correction low", lo, 36);
      check(hi == 36, "R6 capped correction high", hi, 36);
   endtask

   task automatic t_stretch();
      int lo, wt, hi, nf, nr;
      stretch_s = 10;
      start(0, 2, 2);
      measure(lo, wt, hi, nf, nr);
      check(lo == 9, "R3 low before stretch", lo, 9);
      check(wt == 10, "R5 stretched wait", wt, 10);
      check(hi == 9, "R5 high count after stretch", hi, 9);
      stretch_s = 0;
   endtask

   task automatic t_midchange();
      int lo, wt, hi, nf, nr;
      start(0, 10, 10);
      while (!tick_fall) @(negedge clk);
      low_val = PER_W'(30); high_val = PER_W'(5);
      measure(lo, wt, hi, nf, nr);
      check(lo == 17, "R7 current low unchanged", lo, 17);
      check(hi == 12, "R7 next high uses new value", hi, 12);
      measure(lo, wt, hi, nf, nr);
      check(lo == 37, "R7 next low uses new value", lo, 37);
   endtask

   task automatic t_stop();
      int seen;
      start(0, 20, 20);
      while (!tick_fall) @(negedge clk);
      repeat (3) @(negedge clk);
      active = 1'b0;
      @(negedge clk);
      check(scl_drive_low == 0, "R9 release after stop", int'(scl_drive_low), 0);
      seen = 0;
      repeat (30) begin
         @(negedge clk);
         if (scl_drive_low || tick_fall || tick_rise) seen++;
      end
      check(seen == 0, "R9 quiet after stop", seen, 0);
      active = 1'b1; enable = 1'b1;
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check(scl_drive_low == 0, "R9 release after disable", int'(scl_drive_low), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_idle();
      enable = 1'b1;
      t_basic();
      t_prescale();
      t_cap();
      t_stretch();
      t_midchange();
      t_stop();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule